// File: doc/BRIEF.md
# Sub-Block Victim Cache

This block is a small fully associative store that sits beside a column-buffer data cache whose lines are 512 bytes long. When the main cache replaces one of its lines, only the 32-byte sub-block that was touched last is kept here. The copy moves one 64-bit word per cycle out of the outgoing column buffer. It takes four cycles and fits inside the DRAM array latency of the miss that caused the replacement, so it adds no stall.

Every processor access probes all entries at the same time as the main cache lookup, and a hit in either one satisfies the access. Stores that hit an entry update the stored word in place, so the block never holds a stale copy. The line sizes differ, so contents never flow back into the main cache. Replacement among the entries is least-recently-used. Hits and new captures both count as uses.

Top module: `sub_block_victim_cache`

## Requirements
- R1: After reset no entry is valid. rsp_valid, rsp_hit and ev_busy are 0, and every lookup misses.
- R2: A lookup presented with lk_valid=1 at a clock edge gets its answer at the next edge. At that edge rsp_valid=1, rsp_hit tells whether a valid entry holds lk_blk_addr, and rsp_rdata is the 64-bit word number lk_word (0 to 3) of that entry, or 0 on a miss. When lk_valid=0, rsp_valid is 0 one cycle later.
- R3: An ev_start accepted while idle raises ev_busy for exactly four cycles. During those cycles ev_rd_idx steps through 0, 1, 2 and 3, and the ev_rd_data seen in each cycle becomes word ev_rd_idx of the captured entry. The entry answers lookups from the cycle after ev_busy falls.
- R4: Up to 16 distinct 32-byte block addresses are held at once, in any combination.
- R5: When all 16 entries are valid, a capture of a new address replaces the entry that was used least recently. Uses are lookup hits and captures.
- R6: A lookup hit, load or store, makes that entry the most recently used.
- R7: A capture of an address that is already held overwrites that entry with the new data and makes it most recently used. No second copy is made and no other entry is displaced.
- R8: A store (lk_write=1) that hits replaces only word lk_word of the entry and leaves the other three words unchanged. rsp_rdata returns the word as it was before the store. A store that misses changes no entry.
- R9: While fewer than 16 entries are valid, a capture of a new address uses a free entry and no held address is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | Lookup is a store |
| lk_blk_addr | input | 26 | 32-byte block address of the access |
| lk_word | input | 2 | 64-bit word within the block |
| lk_wdata | input | 64 | Store data |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_hit | output | 1 | Lookup hit an entry |
| rsp_rdata | output | 64 | Word read on a hit, 0 on a miss |
| ev_start | input | 1 | Main cache replaces a line; capture begins |
| ev_blk_addr | input | 26 | Block address of the last-touched sub-block of the outgoing line |
| ev_rd_idx | output | 2 | Word of the outgoing sub-block to present on ev_rd_data |
| ev_rd_data | input | 64 | Word read from the outgoing column buffer |
| ev_busy | output | 1 | Capture in progress |

## Verification
The assertions assume that the processor is frozen while a capture runs. No lookup arrives in the same cycle as ev_start or while ev_busy is high, and ev_rd_data carries the requested word in the same cycle as ev_rd_idx. The bench serializes its operations to respect this. Each lookup or capture finishes, and ev_busy is seen low, before the next one is driven. Random traffic uses an address pool larger than 16 entries, so hits, misses, replacements and recaptures all occur, and directed sequences pin down the least-recently-used order.

// File: rtl/vc_pkg.sv
// Shared types for the sub-block victim cache.
package vc_pkg;
    // State of the capture sequencer.
    typedef enum logic [0:0] {
        CP_IDLE = 1'b0,
        CP_COPY = 1'b1
    } copy_state_e;
endpackage

// File: rtl/vc_tag_match.sv
// Fully associative tag compare.
// Compares one probe address against every valid entry at once and returns
// a match vector, a flag and an encoded index.
// Assumes the tag array never holds the same valid address twice.
module vc_tag_match #(
    parameter int N_ENT  = 16,
    parameter int BLK_AW = 26,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0]             ent_valid,
    input  logic [N_ENT-1:0][BLK_AW-1:0] ent_tag,
    input  logic [BLK_AW-1:0]            probe_addr,
    output logic [N_ENT-1:0]             match_vec,
    output logic                         any_match,
    output logic [IDX_W-1:0]             match_idx
);
    // One comparator per entry.
    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign match_vec[g] = ent_valid[g] && (ent_tag[g] == probe_addr);
    end

    // Encode the match vector; the vector is one-hot or empty.
    always_comb begin
        match_idx = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (match_vec[i]) match_idx = IDX_W'(i);
        end
    end

    assign any_match = |match_vec;
endmodule

// File: rtl/vc_age_lru.sv
// Least-recently-used tracker kept as an age ordering.
// Every entry holds a distinct age: 0 is most recent and N_ENT-1 is oldest.
// A touch moves the entry to age 0 and ages by one every entry that was
// younger than it. Assumes at most one touch per cycle.
module vc_age_lru #(
    parameter int N_ENT  = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] oldest_idx
);
    logic [N_ENT-1:0][IDX_W-1:0] age_q;
    logic [IDX_W-1:0]            touch_age;

    // Age of the entry being touched.
    assign touch_age = age_q[touch_idx];

    // Update the ordering on a touch; reset loads a permutation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) age_q[i] <= IDX_W'(i);
        end else if (touch_en) begin
            for (int i = 0; i < N_ENT; i++) begin
                if (IDX_W'(i) == touch_idx)   age_q[i] <= '0;
                else if (age_q[i] < touch_age) age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    // Locate the entry with the largest age.
    always_comb begin
        oldest_idx = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (age_q[i] == IDX_W'(N_ENT - 1)) oldest_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/vc_copy_ctrl.sv
// Capture sequencer.
// On an accepted start it latches the target entry and block address, then
// walks the word index of the outgoing sub-block one word per cycle. In the
// cycle of the last word it raises commit so the entry can be made valid.
// Starts seen while busy are ignored.
module vc_copy_ctrl
    import vc_pkg::*;
#(
    parameter int N_ENT         = 16,
    parameter int BLK_AW        = 26,
    parameter int WORDS_PER_BLK = 4,
    localparam int IDX_W        = $clog2(N_ENT),
    localparam int WSEL_W       = $clog2(WORDS_PER_BLK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  slot_in,
    input  logic [BLK_AW-1:0] addr_in,
    output logic              start_ok,
    output logic              busy,
    output logic [WSEL_W-1:0] word_idx,
    output logic              commit,
    output logic [IDX_W-1:0]  cp_slot,
    output logic [BLK_AW-1:0] cp_addr
);
    localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(WORDS_PER_BLK - 1);

    copy_state_e       state_q;
    logic [WSEL_W-1:0] cnt_q;

    assign start_ok = start && (state_q == CP_IDLE);
    assign busy     = (state_q == CP_COPY);
    assign word_idx = cnt_q;
    assign commit   = busy && (cnt_q == LAST_WORD);

    // Sequence the word index and hold the target of the capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CP_IDLE;
            cnt_q   <= '0;
            cp_slot <= '0;
            cp_addr <= '0;
        end else if (start_ok) begin
            state_q <= CP_COPY;
            cnt_q   <= '0;
            cp_slot <= slot_in;
            cp_addr <= addr_in;
        end else if (busy) begin
            if (cnt_q == LAST_WORD) begin
                state_q <= CP_IDLE;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vc_data_store.sv
// Data array of the victim cache: N_ENT entries of WORDS_PER_BLK words.
// One write port and one asynchronous read port, each addressed by
// entry and word. The caller keeps at most one writer active per cycle.
module vc_data_store #(
    parameter int N_ENT         = 16,
    parameter int WORD_W        = 64,
    parameter int WORDS_PER_BLK = 4,
    localparam int IDX_W        = $clog2(N_ENT),
    localparam int WSEL_W       = $clog2(WORDS_PER_BLK)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_slot,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_slot,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem_q [N_ENT][WORDS_PER_BLK];

    // Write one word.
    always_ff @(posedge clk) begin
        if (we) mem_q[wr_slot][wr_word] <= wr_data;
    end

    // Read one word combinationally.
    assign rd_data = mem_q[rd_slot][rd_word];
endmodule

// File: rtl/sub_block_victim_cache.sv
// Sub-block victim cache, top level.
// Holds N_ENT copies of 32-byte sub-blocks taken from lines that the main
// column-buffer cache replaces. Lookups are answered one cycle after they
// are presented. Captures copy one word per cycle from the outgoing buffer.
// Assumes the processor is frozen while a capture runs: no lookup arrives
// with ev_start or while ev_busy is high.
module sub_block_victim_cache
    import vc_pkg::*;
#(
    parameter int N_ENT         = 16,
    parameter int BLK_AW        = 26,
    parameter int WORD_W        = 64,
    parameter int WORDS_PER_BLK = 4,
    localparam int IDX_W        = $clog2(N_ENT),
    localparam int WSEL_W       = $clog2(WORDS_PER_BLK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_write,
    input  logic [BLK_AW-1:0] lk_blk_addr,
    input  logic [WSEL_W-1:0] lk_word,
    input  logic [WORD_W-1:0] lk_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WORD_W-1:0] rsp_rdata,
    input  logic              ev_start,
    input  logic [BLK_AW-1:0] ev_blk_addr,
    output logic [WSEL_W-1:0] ev_rd_idx,
    input  logic [WORD_W-1:0] ev_rd_data,
    output logic              ev_busy
);
    logic [N_ENT-1:0]             ent_valid;
    logic [N_ENT-1:0][BLK_AW-1:0] ent_tag;
    logic [BLK_AW-1:0]            probe_addr;
    logic [N_ENT-1:0]             match_vec;
    logic                         any_match;
    logic [IDX_W-1:0]             match_idx;
    logic [IDX_W-1:0]             oldest_idx;
    logic                         free_any;
    logic [IDX_W-1:0]             free_idx;
    logic [IDX_W-1:0]             alloc_slot;
    logic                         start_ok;
    logic                         copy_busy;
    logic [WSEL_W-1:0]            copy_word;
    logic                         commit;
    logic [IDX_W-1:0]             cp_slot;
    logic [BLK_AW-1:0]            cp_addr;
    logic                         lk_hit;
    logic                         st_hit;
    logic                         dw_en;
    logic [IDX_W-1:0]             dw_slot;
    logic [WSEL_W-1:0]            dw_word;
    logic [WORD_W-1:0]            dw_data;
    logic [WORD_W-1:0]            rd_word_data;
    logic                         touch_en;
    logic [IDX_W-1:0]             touch_idx;

    // One comparator bank serves both lookups and captures; they never overlap.
    assign probe_addr = ev_start ? ev_blk_addr : lk_blk_addr;
    assign lk_hit     = lk_valid && !ev_start && any_match;
    assign st_hit     = lk_hit && lk_write;

    vc_tag_match #(
        .N_ENT  (N_ENT),
        .BLK_AW (BLK_AW)
    ) u_match (
        .ent_valid  (ent_valid),
        .ent_tag    (ent_tag),
        .probe_addr (probe_addr),
        .match_vec  (match_vec),
        .any_match  (any_match),
        .match_idx  (match_idx)
    );

    // Lowest-numbered free entry, if there is one.
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // Capture target: the same address, else a free entry, else the oldest.
    always_comb begin
        if (any_match)     alloc_slot = match_idx;
        else if (free_any) alloc_slot = free_idx;
        else               alloc_slot = oldest_idx;
    end

    vc_copy_ctrl #(
        .N_ENT         (N_ENT),
        .BLK_AW        (BLK_AW),
        .WORDS_PER_BLK (WORDS_PER_BLK)
    ) u_copy (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (ev_start),
        .slot_in  (alloc_slot),
        .addr_in  (ev_blk_addr),
        .start_ok (start_ok),
        .busy     (copy_busy),
        .word_idx (copy_word),
        .commit   (commit),
        .cp_slot  (cp_slot),
        .cp_addr  (cp_addr)
    );

    assign ev_busy   = copy_busy;
    assign ev_rd_idx = copy_word;

    // Validity and tags: drop the target at start, publish it at commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_tag   <= '0;
        end else begin
            if (start_ok) ent_valid[alloc_slot] <= 1'b0;
            if (commit) begin
                ent_valid[cp_slot] <= 1'b1;
                ent_tag[cp_slot]   <= cp_addr;
            end
        end
    end

    // Data write port: capture words, or a store that hit.
    always_comb begin
        if (copy_busy) begin
            dw_en   = 1'b1;
            dw_slot = cp_slot;
            dw_word = copy_word;
            dw_data = ev_rd_data;
        end else begin
            dw_en   = st_hit;
            dw_slot = match_idx;
            dw_word = lk_word;
            dw_data = lk_wdata;
        end
    end

    vc_data_store #(
        .N_ENT         (N_ENT),
        .WORD_W        (WORD_W),
        .WORDS_PER_BLK (WORDS_PER_BLK)
    ) u_data (
        .clk     (clk),
        .we      (dw_en),
        .wr_slot (dw_slot),
        .wr_word (dw_word),
        .wr_data (dw_data),
        .rd_slot (match_idx),
        .rd_word (lk_word),
        .rd_data (rd_word_data)
    );

    // Recency update: a lookup hit or a committed capture.
    assign touch_en  = lk_hit || commit;
    assign touch_idx = commit ? cp_slot : match_idx;

    vc_age_lru #(
        .N_ENT (N_ENT)
    ) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .oldest_idx (oldest_idx)
    );

    // Register the lookup answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_hit;
            rsp_rdata <= lk_hit ? rd_word_data : '0;
        end
    end
endmodule

// File: rtl/vc_checker.sv
// Protocol and structure checks for the sub-block victim cache.
// Attached to every instance of the top through the bind below.
module vc_checker #(
    parameter int N_ENT         = 16,
    parameter int WORDS_PER_BLK = 4,
    localparam int WSEL_W       = $clog2(WORDS_PER_BLK)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              ev_start,
    input logic              ev_busy,
    input logic [WSEL_W-1:0] ev_rd_idx,
    input logic [N_ENT-1:0]  match_vec,
    input logic [N_ENT-1:0]  ent_valid
);
    localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(WORDS_PER_BLK - 1);

    // R2: every lookup is answered one cycle later.
    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    // R2: no answer without a request.
    assert_rsp_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    // R1: a hit is only reported with a valid answer.
    assert_hit_in_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);
    // R7: an address never matches two entries.
    assert_single_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));
    // R3: an accepted start begins the walk at word 0.
    assert_copy_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && !ev_busy) |=> (ev_busy && ev_rd_idx == '0));
    // R3: the walk advances one word per cycle.
    assert_copy_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_busy && ev_rd_idx != LAST_WORD) |=> (ev_busy && ev_rd_idx == $past(ev_rd_idx) + 1'b1));
    // R3: the walk ends after the last word.
    assert_copy_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_busy && ev_rd_idx == LAST_WORD) |=> !ev_busy);
    // R3: environment keeps lookups out of a capture.
    assert_no_lookup_in_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_valid && (ev_busy || ev_start)));
    // R9: while the capture target is invalid, at most one entry drops per cycle.
    assert_valid_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ent_valid) + 1 >= $countones($past(ent_valid)));
endmodule

bind sub_block_victim_cache vc_checker #(
    .N_ENT         (N_ENT),
    .WORDS_PER_BLK (WORDS_PER_BLK)
) u_vc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .ev_start  (ev_start),
    .ev_busy   (ev_busy),
    .ev_rd_idx (ev_rd_idx),
    .match_vec (match_vec),
    .ent_valid (ent_valid)
);

// File: tb/test_sub_block_victim_cache.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, checked against
// a recency-stamped model of the requirements.
module test_sub_block_victim_cache;
    localparam int N_ENT = 16;
    localparam int AW    = 26;
    localparam int WW    = 64;
    localparam int WPB   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic          lk_write = 1'b0;
    logic [AW-1:0] lk_blk_addr = '0;
    logic [1:0]    lk_word = '0;
    logic [WW-1:0] lk_wdata = '0;
    logic          rsp_valid;
    logic          rsp_hit;
    logic [WW-1:0] rsp_rdata;
    logic          ev_start = 1'b0;
    logic [AW-1:0] ev_blk_addr = '0;
    logic [1:0]    ev_rd_idx;
    logic [WW-1:0] ev_rd_data;
    logic          ev_busy;
    logic [WW-1:0] ev_buf [WPB];

    int n_total = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    assign ev_rd_data = ev_buf[ev_rd_idx];

    sub_block_victim_cache i_sub_block_victim_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_blk_addr(lk_blk_addr),
        .lk_word(lk_word), .lk_wdata(lk_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .ev_start(ev_start), .ev_blk_addr(ev_blk_addr), .ev_rd_idx(ev_rd_idx),
        .ev_rd_data(ev_rd_data), .ev_busy(ev_busy)
    );

    // Model state.
    bit            m_val [N_ENT];
    logic [AW-1:0] m_tag [N_ENT];
    logic [WW-1:0] m_dat [N_ENT][WPB];
    int            m_stamp [N_ENT];
    int            stamp_ctr = 0;

    function automatic int m_find(input logic [AW-1:0] a);
        for (int i = 0; i < N_ENT; i++)
            if (m_val[i] && m_tag[i] == a) return i;
        return -1;
    endfunction

    function automatic int m_victim_slot(input logic [AW-1:0] a);
        int k;
        int best;
        k = m_find(a);
        if (k >= 0) return k;
        for (int i = 0; i < N_ENT; i++) if (!m_val[i]) return i;
        best = 0;
        for (int i = 1; i < N_ENT; i++) if (m_stamp[i] < m_stamp[best]) best = i;
        return best;
    endfunction

    function automatic logic [AW-1:0] pool_addr(input int i);
        return AW'(i * 37 + 5);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [WW-1:0] act, input logic [WW-1:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One lookup; checks the answer and updates the model.
    task automatic do_lookup(input logic [AW-1:0] a, input int w, input bit wr,
                             input logic [WW-1:0] wd, input string req);
        int k;
        logic [WW-1:0] exp_d;
        k = m_find(a);
        exp_d = (k >= 0) ? m_dat[k][w] : '0;
        @(negedge clk);
        lk_valid = 1'b1; lk_write = wr; lk_blk_addr = a;
        lk_word = 2'(w); lk_wdata = wd;
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0;
        check(rsp_valid == 1'b1, req, "rsp_valid", WW'(rsp_valid), 64'd1);
        check(rsp_hit == (k >= 0), req, "rsp_hit", WW'(rsp_hit), WW'(k >= 0));
        check(rsp_rdata == exp_d, req, "rsp_rdata", rsp_rdata, exp_d);
        if (k >= 0) begin
            if (wr) m_dat[k][w] = wd;
            stamp_ctr++;
            m_stamp[k] = stamp_ctr;
        end
    endtask

    // One capture of block address a with fresh random data.
    task automatic do_evict(input logic [AW-1:0] a, input string req);
        int s;
        for (int j = 0; j < WPB; j++) ev_buf[j] = {$urandom, $urandom};
        s = m_victim_slot(a);
        m_val[s] = 1'b1;
        m_tag[s] = a;
        for (int j = 0; j < WPB; j++) m_dat[s][j] = ev_buf[j];
        stamp_ctr++;
        m_stamp[s] = stamp_ctr;
        @(negedge clk);
        ev_start = 1'b1; ev_blk_addr = a;
        @(negedge clk);
        ev_start = 1'b0;
        for (int j = 0; j < WPB; j++) begin
            check(ev_busy == 1'b1, req, "ev_busy during copy", WW'(ev_busy), 64'd1);
            check(ev_rd_idx == 2'(j), req, "ev_rd_idx", WW'(ev_rd_idx), WW'(j));
            @(negedge clk);
        end
        check(ev_busy == 1'b0, req, "ev_busy after copy", WW'(ev_busy), 64'd0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        int r;
        int lost;
        void'($urandom(32'h5eed_0042));
        for (int j = 0; j < WPB; j++) ev_buf[j] = '0;
        for (int i = 0; i < N_ENT; i++) begin
            m_val[i] = 1'b0; m_tag[i] = '0; m_stamp[i] = 0;
            for (int j = 0; j < WPB; j++) m_dat[i][j] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        check(rsp_valid == 1'b0, "R1", "rsp_valid", WW'(rsp_valid), 64'd0);
        check(ev_busy == 1'b0, "R1", "ev_busy", WW'(ev_busy), 64'd0);
        do_lookup(pool_addr(0), 0, 1'b0, '0, "R1");

        // R2 and R3: a single capture, then a read of every word.
        do_evict(pool_addr(0), "R3");
        for (int j = 0; j < WPB; j++) do_lookup(pool_addr(0), j, 1'b0, '0, "R2");

        // R4 and R9: fill to 16, all must still hit.
        for (int i = 1; i < N_ENT; i++) do_evict(pool_addr(i), "R9");
        for (int i = 0; i < N_ENT; i++) do_lookup(pool_addr(i), i % WPB, 1'b0, '0, "R4");

        // R6 and R5: touch the oldest, then the next oldest must be replaced.
        do_lookup(pool_addr(0), 1, 1'b0, '0, "R6");
        do_evict(pool_addr(20), "R5");
        do_lookup(pool_addr(1), 0, 1'b0, '0, "R5");
        do_lookup(pool_addr(0), 2, 1'b0, '0, "R6");
        do_lookup(pool_addr(20), 3, 1'b0, '0, "R5");

        // R7: recapture of a held address keeps every other entry.
        do_evict(pool_addr(5), "R7");
        do_lookup(pool_addr(5), 2, 1'b0, '0, "R7");
        lost = 0;
        for (int i = 0; i < N_ENT; i++) begin
            if (m_find(pool_addr(i)) >= 0) do_lookup(pool_addr(i), 0, 1'b0, '0, "R7");
        end
        do_lookup(pool_addr(20), 0, 1'b0, '0, "R7");

        // R8: store hit changes one word only; store miss changes nothing.
        do_lookup(pool_addr(3), 1, 1'b1, 64'hDEAD_BEEF_0123_4567, "R8");
        do_lookup(pool_addr(3), 1, 1'b0, '0, "R8");
        do_lookup(pool_addr(3), 0, 1'b0, '0, "R8");
        do_lookup(pool_addr(3), 2, 1'b0, '0, "R8");
        do_lookup(pool_addr(33), 0, 1'b1, 64'h1111_2222_3333_4444, "R8");
        do_lookup(pool_addr(33), 0, 1'b0, '0, "R8");

        // Random mix over a 28-address pool.
        for (int n = 0; n < 1500; n++) begin
            r = int'($urandom_range(0, 9));
            if (r < 3)
                do_evict(pool_addr(int'($urandom_range(0, 27))), "R5");
            else if (r < 5)
                do_lookup(pool_addr(int'($urandom_range(0, 27))), int'($urandom_range(0, 3)),
                          1'b1, {$urandom, $urandom}, "R8");
            else
                do_lookup(pool_addr(int'($urandom_range(0, 27))), int'($urandom_range(0, 3)),
                          1'b0, '0, "R6");
        end
        if (lost != 0) check(1'b0, "R7", "lost", WW'(lost), 64'd0);

        $display("  %0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule